// File: doc/BRIEF.md
# ADC Register Front-End

This block is a bus-attached register file that takes the place of an analog-to-digital converter peripheral when no real converter is present. It decodes a 256-byte window of 32-bit words, one word per access. The window holds these registers:

- status
- two control words
- two sample-time words
- four injected-offset words
- high and low thresholds
- three regular-sequence words and one injected-sequence word
- four injected-data words
- the regular-data word

Most of these registers simply store what software writes. A few have masking or side effects on access.

A read of the regular-data word is the only place where "conversion" happens. If the converter is enabled and a software start is pending, the read clears the start request. It also advances an internal synthetic sample by a fixed step and returns that sample formatted by the selected resolution and alignment. Any other regular-data read returns the stored sample untouched. Injected-data reads return the stored value minus the matching offset.

Read data is registered and appears one clock after the read strobe. An error flag pulses for one clock after any access to an undefined word. The interrupt output exists for pin compatibility and never asserts.

Top module: `adc_fe_top`

## Requirements
- R1: After a synchronous reset, every register reads zero except the high-threshold word at offset 0x24, which reads 0x00000FFF. The synthetic sample is also zero after reset, and so is `rdata`.
- R2: A write to the status word at 0x00 ANDs its 6 stored bits with `wdata[5:0]`. A status bit can be cleared but never set.
- R3: A read of control word 2 at 0x08 returns stored bits 27:0, and bits 31:28 read as zero.
- R4: The four injected-offset words at 0x14, 0x18, 0x1C and 0x20 keep only `wdata[11:0]` on a write.
- R5: A read of injected-data word n (0x3C + 4·(n−1), n = 1..4) returns the stored 32-bit value minus injected offset n, modulo 2^32.
- R6: The converter is triggered when control word 2 has its enable bit (bit 0) and its start bit (bit 30) both set. A read of the regular-data word at 0x4C while triggered does three things: it adds 7 to the sample, clears the start bit, and returns the formatted new sample.
- R7: With alignment off, the triggered result is the sample masked by the resolution field, bits 25:24 of control word 1: 00 → 0xFFF, 01 → 0x3FF, 10 → 0xFF, 11 → 0x3F.
- R8: With the alignment bit set (bit 11 of control word 2), the triggered result is (sample << 1) & 0xFFF0, whatever the resolution.
- R9: A regular-data read when the converter is not triggered returns the raw stored sample, and leaves both the sample and the start bit unchanged.
- R10: Accesses to word offsets above 0x4C (0x50 to 0xFC) have these effects:
  - a read returns zero;
  - a write is dropped;
  - `err` is high in the clock after the access and low in the clock after any other cycle.
- R11: The sample-time, low-threshold, high-threshold, regular-sequence and injected-sequence words store and return all 32 written bits. Writes to the regular-data word have no effect.
- R12: `irq` is low at all times.
- R13: `rdata` changes only on the clock edge that samples `rd_en`, and holds its value across cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| err | output | 1 | One-cycle pulse after an access to an undefined word |
| irq | output | 1 | Interrupt, tied inactive |

## Verification
On every cycle, the bound checker confirms these properties:
- the interrupt stays low;
- the error flag follows bad-address accesses exactly one cycle later;
- control word 2 never exposes its top nibble;
- status bits never appear from a write;
- a triggered data read steps the sample by 7 and drops the start bit, while every other cycle leaves the sample alone;
- read data holds between reads.

The resolution and alignment formatting, the offset subtraction on injected reads, the 12-bit offset truncation and the reset values depend on specific data. Only the bench scenarios show them: a vector table, a sweep that drives the sample past 4095 through all four resolutions with and without alignment, and a reset after registers have been disturbed.

// File: rtl/adc_fe_pkg.sv
// Package: shared constants, register kinds and the sample formatter for the
// ADC register front-end. Assumes a 32-bit data path and at most 8 entries
// in any replicated register group.
package adc_fe_pkg;

    localparam int DATA_W       = 32;
    localparam int SUB_W        = 3;
    localparam int SR_W         = 6;
    localparam int OFS_W        = 12;
    localparam int CR2_RD_BITS  = 28;
    localparam int EN_BIT       = 0;
    localparam int ALIGN_BIT    = 11;
    localparam int START_BIT    = 30;
    localparam int RES_LO       = 24;
    localparam int CR1_WORD     = 1;
    localparam int CR2_WORD     = 2;

    typedef enum logic [3:0] {
        K_STAT, K_CTL1, K_CTL2, K_SMP, K_OFS, K_HI, K_LO,
        K_SEQ, K_JSEQ, K_JDAT, K_DAT, K_BAD
    } reg_kind_e;

    // Format a sample by resolution, or by left alignment when requested.
    function automatic logic [DATA_W-1:0] fmt_sample(
        input logic [DATA_W-1:0] s,
        input logic [1:0]        res,
        input logic              left
    );
        logic [DATA_W-1:0] v;
        if (left) begin
            v = (s << 1) & DATA_W'(32'h0000_FFF0);
        end else begin
            case (res)
                2'b00:   v = s & DATA_W'(32'h0000_0FFF);
                2'b01:   v = s & DATA_W'(32'h0000_03FF);
                2'b10:   v = s & DATA_W'(32'h0000_00FF);
                default: v = s & DATA_W'(32'h0000_003F);
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/adc_fe_decode.sv
// Module: word-address decoder. Maps a word index to a register kind and an
// entry number within a replicated group. Assumes groups are laid out
// back to back in the fixed order below; any index past the data word is bad.
module adc_fe_decode
    import adc_fe_pkg::*;
#(
    parameter int WORD_W = 6,
    parameter int N_SMP  = 2,
    parameter int N_INJ  = 4,
    parameter int N_SEQ  = 3
) (
    input  logic [WORD_W-1:0] word,
    output reg_kind_e         kind,
    output logic [SUB_W-1:0]  sub
);

    localparam int SMP_B = 3;
    localparam int OFS_B = SMP_B + N_SMP;
    localparam int HI_B  = OFS_B + N_INJ;
    localparam int LO_B  = HI_B + 1;
    localparam int SEQ_B = LO_B + 1;
    localparam int JSQ_B = SEQ_B + N_SEQ;
    localparam int JD_B  = JSQ_B + 1;
    localparam int DAT_B = JD_B + N_INJ;

    int w;
    assign w = int'(word);

    // Range-compare the word index against each group base.
    always_comb begin
        kind = K_BAD;
        sub  = '0;
        if (w == 0) begin
            kind = K_STAT;
        end else if (w == 1) begin
            kind = K_CTL1;
        end else if (w == 2) begin
            kind = K_CTL2;
        end else if (w >= SMP_B && w < OFS_B) begin
            kind = K_SMP;
            sub  = SUB_W'(w - SMP_B);
        end else if (w >= OFS_B && w < HI_B) begin
            kind = K_OFS;
            sub  = SUB_W'(w - OFS_B);
        end else if (w == HI_B) begin
            kind = K_HI;
        end else if (w == LO_B) begin
            kind = K_LO;
        end else if (w >= SEQ_B && w < JSQ_B) begin
            kind = K_SEQ;
            sub  = SUB_W'(w - SEQ_B);
        end else if (w == JSQ_B) begin
            kind = K_JSEQ;
        end else if (w >= JD_B && w < DAT_B) begin
            kind = K_JDAT;
            sub  = SUB_W'(w - JD_B);
        end else if (w == DAT_B) begin
            kind = K_DAT;
        end
    end

endmodule

// File: rtl/adc_fe_regs.sv
// Module: register storage. Applies write masking (status clear-only,
// offsets truncated to 12 bits) and the start-bit self-clear. Assumes the
// caller never writes control word 2 in the same cycle as a triggered read
// (they decode to different words).
module adc_fe_regs
    import adc_fe_pkg::*;
#(
    parameter int                N_SMP    = 2,
    parameter int                N_INJ    = 4,
    parameter int                N_SEQ    = 3,
    parameter logic [DATA_W-1:0] HI_RESET = 32'h0000_0FFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  reg_kind_e                     kind,
    input  logic [SUB_W-1:0]              sub,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          clr_start,
    output logic [SR_W-1:0]               sr_q,
    output logic [DATA_W-1:0]             cr1_q,
    output logic [DATA_W-1:0]             cr2_q,
    output logic [N_SMP-1:0][DATA_W-1:0]  smp_q,
    output logic [N_INJ-1:0][OFS_W-1:0]   ofs_q,
    output logic [DATA_W-1:0]             hi_q,
    output logic [DATA_W-1:0]             lo_q,
    output logic [N_SEQ-1:0][DATA_W-1:0]  seq_q,
    output logic [DATA_W-1:0]             jseq_q,
    output logic [N_INJ-1:0][DATA_W-1:0]  jd_q
);

    // Status: bits may only be cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sr_q <= '0;
        else if (we && kind == K_STAT)   sr_q <= sr_q & wdata[SR_W-1:0];
    end

    // Control word 1: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cr1_q <= '0;
        else if (we && kind == K_CTL1)   cr1_q <= wdata;
    end

    // Control word 2: storage plus start-bit clear on a triggered read.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cr2_q <= '0;
        else if (we && kind == K_CTL2)   cr2_q <= wdata;
        else if (clr_start)              cr2_q[START_BIT] <= 1'b0;
    end

    // Thresholds: high resets to full scale, low to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= HI_RESET;
            lo_q <= '0;
        end else if (we && kind == K_HI) begin
            hi_q <= wdata;
        end else if (we && kind == K_LO) begin
            lo_q <= wdata;
        end
    end

    // Injected sequence word: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                      jseq_q <= '0;
        else if (we && kind == K_JSEQ)   jseq_q <= wdata;
    end

    genvar i;
    generate
        for (i = 0; i < N_SMP; i++) begin : g_smp
            // Sample-time word i.
            always_ff @(posedge clk) begin
                if (!rst_n) smp_q[i] <= '0;
                else if (we && kind == K_SMP && sub == SUB_W'(i)) smp_q[i] <= wdata;
            end
        end
        for (i = 0; i < N_SEQ; i++) begin : g_seq
            // Regular sequence word i.
            always_ff @(posedge clk) begin
                if (!rst_n) seq_q[i] <= '0;
                else if (we && kind == K_SEQ && sub == SUB_W'(i)) seq_q[i] <= wdata;
            end
        end
        for (i = 0; i < N_INJ; i++) begin : g_inj
            // Injected offset i keeps only its low 12 bits.
            always_ff @(posedge clk) begin
                if (!rst_n) ofs_q[i] <= '0;
                else if (we && kind == K_OFS && sub == SUB_W'(i)) ofs_q[i] <= wdata[OFS_W-1:0];
            end
            // Injected data i stores the full word.
            always_ff @(posedge clk) begin
                if (!rst_n) jd_q[i] <= '0;
                else if (we && kind == K_JDAT && sub == SUB_W'(i)) jd_q[i] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/adc_fe_sample.sv
// Module: synthetic sample source. Holds the raw sample, steps it on a
// triggered read and presents the formatted stepped value in the same cycle.
// Assumes the step wraps modulo 2^32.
module adc_fe_sample
    import adc_fe_pkg::*;
#(
    parameter int STEP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [1:0]        res,
    input  logic              left,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] fmt_next
);

    logic [DATA_W-1:0] next;
    assign next = raw_q + DATA_W'(STEP);

    // Format the value the sample takes after this step.
    assign fmt_next = fmt_sample(next, res, left);

    // Advance the sample only on a triggered read.
    always_ff @(posedge clk) begin
        if (!rst_n)    raw_q <= '0;
        else if (fire) raw_q <= next;
    end

endmodule

// File: rtl/adc_fe_top.sv
// Module: ADC register front-end top. Decodes the bus access and drives the
// register file and sample source. Builds the registered read data and the
// bad-address error pulse. Assumes single-cycle strobes; a cycle with
// both strobes acts on the same word for both.
module adc_fe_top
    import adc_fe_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                N_SMP    = 2,
    parameter int                N_INJ    = 4,
    parameter int                N_SEQ    = 3,
    parameter int                STEP     = 7,
    parameter logic [DATA_W-1:0] HI_RESET = 32'h0000_0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              irq
);

    localparam int WORD_W    = ADDR_W - 2;
    localparam int LAST_WORD = 3 + N_SMP + N_INJ + 2 + N_SEQ + 1 + N_INJ;

    logic [WORD_W-1:0] word;
    logic              unused_lsb;
    reg_kind_e         kind;
    logic [SUB_W-1:0]  sub;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    logic [SR_W-1:0]              sr_q;
    logic [DATA_W-1:0]            cr1_q, cr2_q, hi_q, lo_q, jseq_q;
    logic [N_SMP-1:0][DATA_W-1:0] smp_q;
    logic [N_INJ-1:0][OFS_W-1:0]  ofs_q;
    logic [N_SEQ-1:0][DATA_W-1:0] seq_q;
    logic [N_INJ-1:0][DATA_W-1:0] jd_q;
    logic [DATA_W-1:0]            sample_q, fmt_next;
    logic                         fire;
    logic [DATA_W-1:0]            rd_val;
    logic [DATA_W-1:0]            rdata_q;
    logic                         err_q;

    adc_fe_decode #(
        .WORD_W (WORD_W),
        .N_SMP  (N_SMP),
        .N_INJ  (N_INJ),
        .N_SEQ  (N_SEQ)
    ) u_dec (
        .word (word),
        .kind (kind),
        .sub  (sub)
    );

    // Triggered read: data word read with enable and start both set.
    assign fire = rd_en && (kind == K_DAT) && cr2_q[EN_BIT] && cr2_q[START_BIT];

    adc_fe_regs #(
        .N_SMP    (N_SMP),
        .N_INJ    (N_INJ),
        .N_SEQ    (N_SEQ),
        .HI_RESET (HI_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .kind      (kind),
        .sub       (sub),
        .wdata     (wdata),
        .clr_start (fire),
        .sr_q      (sr_q),
        .cr1_q     (cr1_q),
        .cr2_q     (cr2_q),
        .smp_q     (smp_q),
        .ofs_q     (ofs_q),
        .hi_q      (hi_q),
        .lo_q      (lo_q),
        .seq_q     (seq_q),
        .jseq_q    (jseq_q),
        .jd_q      (jd_q)
    );

    adc_fe_sample #(
        .STEP (STEP)
    ) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .res      (cr1_q[RES_LO+1:RES_LO]),
        .left     (cr2_q[ALIGN_BIT]),
        .raw_q    (sample_q),
        .fmt_next (fmt_next)
    );

    // Select the read value for the decoded word.
    always_comb begin
        rd_val = '0;
        case (kind)
            K_STAT: rd_val = DATA_W'(sr_q);
            K_CTL1: rd_val = cr1_q;
            K_CTL2: rd_val = DATA_W'(cr2_q[CR2_RD_BITS-1:0]);
            K_SMP: begin
                for (int i = 0; i < N_SMP; i++)
                    if (sub == SUB_W'(i)) rd_val = smp_q[i];
            end
            K_OFS: begin
                for (int i = 0; i < N_INJ; i++)
                    if (sub == SUB_W'(i)) rd_val = DATA_W'(ofs_q[i]);
            end
            K_HI:   rd_val = hi_q;
            K_LO:   rd_val = lo_q;
            K_SEQ: begin
                for (int i = 0; i < N_SEQ; i++)
                    if (sub == SUB_W'(i)) rd_val = seq_q[i];
            end
            K_JSEQ: rd_val = jseq_q;
            K_JDAT: begin
                for (int i = 0; i < N_INJ; i++)
                    if (sub == SUB_W'(i)) rd_val = jd_q[i] - DATA_W'(ofs_q[i]);
            end
            K_DAT:  rd_val = fire ? fmt_next : sample_q;
            default: rd_val = '0;
        endcase
    end

    // Register read data only when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    // Flag any access that lands on an undefined word.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (rd_en || wr_en) && (kind == K_BAD);
    end

    assign rdata = rdata_q;
    assign err   = err_q;
    assign irq   = 1'b0;

endmodule

// File: rtl/adc_fe_checker.sv
// Module: property checker for the ADC register front-end, bound to the top.
// Assumes reset is held low across the first clock edge.
module adc_fe_checker
    import adc_fe_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int STEP      = 7,
    parameter int LAST_WORD = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              err,
    input logic              irq,
    input logic [DATA_W-1:0] sample_q,
    input logic [DATA_W-1:0] cr2_q,
    input logic [SR_W-1:0]   sr_q
);

    logic bad_acc, dat_rd, trig_rd;
    assign bad_acc = (rd_en || wr_en) && (int'(addr[ADDR_W-1:2]) > LAST_WORD);
    assign dat_rd  = rd_en && (int'(addr[ADDR_W-1:2]) == LAST_WORD);
    assign trig_rd = dat_rd && cr2_q[EN_BIT] && cr2_q[START_BIT];

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq == 1'b0);                                                     // R12
    AST_ERR_FOLLOWS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> err);                                                 // R10
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_acc |=> !err);                                               // R10
    AST_CTL2_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr[ADDR_W-1:2]) == CR2_WORD) |=> rdata[31:28] == 4'h0); // R3
    AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sr_q & ~$past(sr_q)) == '0);                           // R2
    AST_TRIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rd |=> (sample_q == $past(sample_q) + DATA_W'(STEP)) && !cr2_q[START_BIT]); // R6
    AST_IDLE_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_rd |=> $stable(sample_q));                                  // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));                                       // R13

endmodule

bind adc_fe_top adc_fe_checker #(
    .ADDR_W    (ADDR_W),
    .STEP      (STEP),
    .LAST_WORD (LAST_WORD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .err      (err),
    .irq      (irq),
    .sample_q (sample_q),
    .cr2_q    (cr2_q),
    .sr_q     (sr_q)
);

// File: tb/adc_fe_top_test.sv
module adc_fe_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        irq;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    logic [31:0] model_s;

    always #2 clk = ~clk;   // 250 MHz

    adc_fe_top uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .err   (err),
        .irq   (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h24, 32'h0,          32'h0000_0FFF, 4'd1 },  // R1 high threshold
        '{1'b0, 8'h28, 32'h0,          32'h0,         4'd1 },  // R1 low threshold
        '{1'b0, 8'h4C, 32'h0,          32'h0,         4'd1 },  // R1 sample
        '{1'b1, 8'h00, 32'hFFFF_FFFF,  32'h0,         4'd2 },  // R2 try to set
        '{1'b0, 8'h00, 32'h0,          32'h0,         4'd2 },
        '{1'b1, 8'h08, 32'hFFFF_FFFF,  32'h0,         4'd3 },
        '{1'b0, 8'h08, 32'h0,          32'h0FFF_FFFF, 4'd3 },  // R3
        '{1'b1, 8'h14, 32'hABCD_E123,  32'h0,         4'd4 },
        '{1'b0, 8'h14, 32'h0,          32'h0000_0123, 4'd4 },  // R4
        '{1'b1, 8'h3C, 32'h0000_1000,  32'h0,         4'd5 },
        '{1'b0, 8'h3C, 32'h0,          32'h0000_0EDD, 4'd5 },  // R5
        '{1'b1, 8'h20, 32'h0000_0005,  32'h0,         4'd5 },
        '{1'b1, 8'h48, 32'h0000_0002,  32'h0,         4'd5 },
        '{1'b0, 8'h48, 32'h0,          32'hFFFF_FFFD, 4'd5 },  // R5 wrap
        '{1'b1, 8'h2C, 32'hDEAD_BEEF,  32'h0,         4'd11},
        '{1'b0, 8'h2C, 32'h0,          32'hDEAD_BEEF, 4'd11},  // R11
        '{1'b1, 8'h10, 32'h1357_9BDF,  32'h0,         4'd11},
        '{1'b0, 8'h10, 32'h0,          32'h1357_9BDF, 4'd11},
        '{1'b1, 8'h08, 32'h4000_0001,  32'h0,         4'd6 },
        '{1'b0, 8'h4C, 32'h0,          32'h0000_0007, 4'd6 },  // R6 first step
        '{1'b0, 8'h4C, 32'h0,          32'h0000_0007, 4'd9 },  // R9 start consumed
        '{1'b1, 8'h4C, 32'h0000_0999,  32'h0,         4'd11},
        '{1'b0, 8'h4C, 32'h0,          32'h0000_0007, 4'd11},  // R11 data write ignored
        '{1'b1, 8'h08, 32'h4000_0801,  32'h0,         4'd8 },
        '{1'b0, 8'h4C, 32'h0,          32'h0000_0010, 4'd8 },  // R8 (14<<1)&FFF0
        '{1'b1, 8'h24, 32'h0,          32'h0,         4'd11},
        '{1'b0, 8'h24, 32'h0,          32'h0,         4'd11}
    };

    function automatic logic [31:0] expect_fmt(input logic [31:0] s,
                                               input int res, input bit left);
        if (left) return (s << 1) & 32'h0000_FFF0;
        case (res)
            0:       return s & 32'h0000_0FFF;
            1:       return s & 32'h0000_03FF;
            2:       return s & 32'h0000_00FF;
            default: return s & 32'h0000_003F;
        endcase
    endfunction

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = wr;
        rd_en = !wr;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, rdata, 32'h0);              // R1 read data after reset
        chk(12, {31'h0, irq}, 32'h0);      // R12

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            acc(VECS[k].wr, VECS[k].a, VECS[k].d);
            chk(10, {31'h0, err}, 32'h0);  // R10 no error on defined words
            if (!VECS[k].wr) chk(int'(VECS[k].req), rdata, VECS[k].exp);
        end
        model_s = 32'd14;

        // R10: undefined words
        acc(1'b1, 8'h50, 32'h1234_5678);
        chk(10, {31'h0, err}, 32'h1);
        @(negedge clk);
        chk(10, {31'h0, err}, 32'h0);
        acc(1'b0, 8'h50, 32'h0);
        chk(10, rdata, 32'h0);
        chk(10, {31'h0, err}, 32'h1);
        acc(1'b0, 8'hFC, 32'h0);
        chk(10, rdata, 32'h0);

        // R13: read data holds across a write and idle cycles
        acc(1'b0, 8'h14, 32'h0);
        acc(1'b1, 8'h28, 32'h0000_0055);
        repeat (2) @(negedge clk);
        chk(13, rdata, 32'h0000_0123);

        // R9: start without enable, and enable without start
        acc(1'b1, 8'h08, 32'h4000_0000);
        acc(1'b0, 8'h4C, 32'h0);
        chk(9, rdata, model_s);
        acc(1'b1, 8'h08, 32'h0000_0001);
        acc(1'b0, 8'h4C, 32'h0);
        chk(9, rdata, model_s);

        // R7 / R8 sweep: sample driven past 4095 across every format
        for (int k = 0; k < 700; k++) begin
            int  res;
            bit  left;
            res  = k % 4;
            left = (k % 5) == 0;
            acc(1'b1, 8'h04, 32'(res) << 24);
            acc(1'b1, 8'h08, 32'h4000_0001 | (32'(left) << 11));
            acc(1'b0, 8'h4C, 32'h0);
            model_s = model_s + 32'd7;
            chk(left ? 8 : 7, rdata, expect_fmt(model_s, res, left));  // R7 / R8
        end
        acc(1'b0, 8'h4C, 32'h0);
        chk(9, rdata, model_s);            // R9 raw sample after sweep

        // R1: reset after disturbing registers
        acc(1'b1, 8'h24, 32'h0);
        acc(1'b1, 8'h08, 32'h4000_0001);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(1, rdata, 32'h0);
        acc(1'b0, 8'h24, 32'h0);
        chk(1, rdata, 32'h0000_0FFF);
        acc(1'b0, 8'h28, 32'h0);
        chk(1, rdata, 32'h0);
        acc(1'b0, 8'h08, 32'h0);
        chk(1, rdata, 32'h0);
        acc(1'b0, 8'h4C, 32'h0);
        chk(1, rdata, 32'h0);
        chk(12, {31'h0, irq}, 32'h0);      // R12

        finish_run();
    end

endmodule